// File: doc/BRIEF.md
# Processor Supervisor with Watchdog

This block keeps a processor in a known state. It holds the processor in reset while the supply is not good. After the supply recovers, it stretches the reset into a fixed pulse. It also accepts an active-low manual reset request, but only after the request has stayed low long enough to rule out bounce. A watchdog timer must be cleared by rising edges on a kick input. If the kicks stop, the watchdog drops an active-low expiry flag. A separate active-low flag mirrors a digital power-fail compare level, so firmware can save its state before the supply collapses.

The expiry flag does not reset the processor by itself. It is fed into the same low-level qualification path as the manual request. A reset therefore follows only once the flag has stayed low for the manual qualification time. The reset pulse then clears the watchdog and raises the flag again.

Every duration is a count of ticks of a free-running millisecond strobe. The strobe is derived from the clock by a prescale parameter. Each duration is therefore exact to within one millisecond plus the input synchronizer latency.

Top module: `mcu_supervisor`

## Requirements
- R1: After `pwrGood` rises, `rstOut` stays high for RESET_MS milliseconds (at least (RESET_MS-1) ms, at most RESET_MS ms plus synchronizer latency), then falls.
- R2: While `pwrGood` is low, `rstOut` is high without waiting for a clock edge. Each return of `pwrGood` starts a new full pulse.
- R3: If `manRstN` goes low for no more than MANUAL_MS ms and then returns high, no reset results and the watchdog flag is left unchanged.
- R4: If `manRstN` is held low for more than MANUAL_MS ms, a reset starts within (MANUAL_MS+1) ms of the press. That reset lasts RESET_MS ms.
- R5: Each rising edge on `wdKick` clears the watchdog. Kicks spaced no more than (WDOG_MS-2) ms apart keep `wdExpN` high and `rstOut` low.
- R6: With no rising edge on `wdKick`, `wdExpN` falls between (WDOG_MS-1) and WDOG_MS ms after the last clear. A `wdKick` held static high gives no clear.
- R7: A low `wdExpN` counts as a manual request. A reset starts between MANUAL_MS and MANUAL_MS+1 ms after the expiry. One cycle after `rstOut` rises, `wdExpN` is high again.
- R8: The watchdog does not count during reset. It restarts from zero when `rstOut` falls, so expiry is timed from that fall.
- R9: `pwrFailN` follows `pfCmpHigh` (1 = level above threshold) two clocks later. It is low while `pwrGood` is low.
- R10: A manual press and a watchdog expiry share one qualification count. A press that starts before the expiry and is still held keeps its accumulated time, so the reset follows the press timing.
- R11: Once `wdExpN` is low, only a reset raises it again. Kicks given after the expiry leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrGood | input | 1 | Supply-good level; low forces reset asynchronously |
| manRstN | input | 1 | Manual reset request, active low, asynchronous |
| wdKick | input | 1 | Watchdog kick; rising edges clear the timer |
| pfCmpHigh | input | 1 | Power-fail compare level, 1 = above threshold |
| rstOut | output | 1 | Processor reset, active high |
| wdExpN | output | 1 | Watchdog expiry flag, active low |
| pwrFailN | output | 1 | Power-fail flag, active low |

## Verification
Two functions can fall in the same window because they share the qualification counter. One is a manual press that is still being qualified. The other is a watchdog expiry that starts qualifying on its own. The bench provokes this by pressing the manual input a few milliseconds before an unfed watchdog expires and holding it. The result is judged by the start of the reset: it must lie within the window measured from the press. A design that restarted qualification at the expiry would land well past that window.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic clrPre;
    logic clrPulse;
    logic runPulse;
    logic clrQual;
    logic clrWdog;
    logic runWdog;
  } supStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic pulseDone;
    logic qualDone;
    logic wdDone;
    logic kickSeen;
  } supStatus_t;

  typedef enum logic {
    ST_RESET = 1'b0,
    ST_RUN   = 1'b1
  } supState_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int RESET_MS = 200,
  parameter int MANUAL_MS = 140,
  parameter int WDOG_MS = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  supStrobe_t strobe,
  input  logic       qualLow,
  input  logic       kickS,
  output supStatus_t status
);

  localparam int PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int QUAL_LIMIT = MANUAL_MS + 1;
  localparam int PULSE_W = $clog2(RESET_MS + 1);
  localparam int QUAL_W = $clog2(QUAL_LIMIT + 1);
  localparam int WD_W = $clog2(WDOG_MS + 1);

  logic [PRE_W-1:0]   preCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic [QUAL_W-1:0]  qualCnt;
  logic [WD_W-1:0]    wdCnt;
  logic               kickPrev;
  logic               msTick;
  logic               kickEdge;

  assign msTick = (preCnt == PRE_W'(CLKS_PER_MS - 1));
  assign kickEdge = kickS && !kickPrev;

  // millisecond prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             preCnt <= '0;
    else if (strobe.clrPre || msTick) preCnt <= '0;
    else                   preCnt <= preCnt + 1'b1;
  end

  // reset pulse length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pulseCnt <= '0;
    else if (strobe.clrPulse) pulseCnt <= '0;
    else if (strobe.runPulse && msTick && pulseCnt != PULSE_W'(RESET_MS))
      pulseCnt <= pulseCnt + 1'b1;
  end

  // low-level qualification counter, shared by manual request and expiry flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          qualCnt <= '0;
    else if (strobe.clrQual || !qualLow) qualCnt <= '0;
    else if (msTick && qualCnt != QUAL_W'(QUAL_LIMIT))
      qualCnt <= qualCnt + 1'b1;
  end

  // kick edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kickPrev <= 1'b0;
    else       kickPrev <= kickS;
  end

  // watchdog timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       wdCnt <= '0;
    else if (strobe.clrWdog || kickEdge) wdCnt <= '0;
    else if (strobe.runWdog && msTick && wdCnt != WD_W'(WDOG_MS))
      wdCnt <= wdCnt + 1'b1;
  end

  assign status.pulseDone = (pulseCnt == PULSE_W'(RESET_MS));
  assign status.qualDone  = (qualCnt == QUAL_W'(QUAL_LIMIT));
  assign status.wdDone    = (wdCnt == WD_W'(WDOG_MS));
  assign status.kickSeen  = kickEdge;

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGoodS,
  input  supStatus_t status,
  output supStrobe_t strobe,
  output logic       rstOut,
  output logic       wdExpN
);

  supState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_RESET;
      rstOut <= 1'b1;
      wdExpN <= 1'b1;
    end else if (!pwrGoodS) begin
      state  <= ST_RESET;
      rstOut <= 1'b1;
      wdExpN <= 1'b1;
    end else begin
      unique case (state)
        ST_RESET: begin
          wdExpN <= 1'b1;
          if (status.pulseDone) begin
            state  <= ST_RUN;
            rstOut <= 1'b0;
          end
        end
        ST_RUN: begin
          if (status.qualDone) begin
            state  <= ST_RESET;
            rstOut <= 1'b1;
          end else if (status.wdDone && !status.kickSeen) begin
            wdExpN <= 1'b0;
          end
        end
        default: begin
          state  <= ST_RESET;
          rstOut <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strobe.clrPre   = !pwrGoodS;
    strobe.clrPulse = !pwrGoodS || (state == ST_RUN);
    strobe.runPulse = (state == ST_RESET);
    strobe.clrQual  = !pwrGoodS || (state == ST_RESET);
    strobe.clrWdog  = !pwrGoodS || (state == ST_RESET);
    strobe.runWdog  = (state == ST_RUN) && wdExpN;
  end

endmodule

// File: rtl/mcu_supervisor.sv
module mcu_supervisor
  import sup_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int RESET_MS = 200,
  parameter int MANUAL_MS = 140,
  parameter int WDOG_MS = 1600,
  parameter int SYNC_STAGES = 2,
  parameter bit WDOG_LOOPED = 1'b1
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic manRstN,
  input  logic wdKick,
  input  logic pfCmpHigh,
  output logic rstOut,
  output logic wdExpN,
  output logic pwrFailN
);

  logic       pwrGoodS;
  logic [2:0] rawIn;
  logic [2:0] syncIn;
  logic       manRstS;
  logic       kickS;
  logic       qualLow;
  supStrobe_t strobe;
  supStatus_t status;

  sup_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RESET_VAL(1'b0)) u_pgSync (
    .clk(clk), .rstN(pwrGood), .dIn(1'b1), .qOut(pwrGoodS)
  );

  assign rawIn = {pfCmpHigh, wdKick, manRstN};

  sup_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RESET_VAL(3'b001)) u_inSync (
    .clk(clk), .rstN(pwrGood), .dIn(rawIn), .qOut(syncIn)
  );

  assign manRstS  = syncIn[0];
  assign kickS    = syncIn[1];
  assign pwrFailN = syncIn[2];

  generate
    if (WDOG_LOOPED) begin : g_loop
      assign qualLow = !manRstS || !wdExpN;
    end else begin : g_noLoop
      assign qualLow = !manRstS;
    end
  endgenerate

  sup_datapath #(
    .CLKS_PER_MS(CLKS_PER_MS), .RESET_MS(RESET_MS),
    .MANUAL_MS(MANUAL_MS), .WDOG_MS(WDOG_MS)
  ) u_dp (
    .clk(clk), .rstN(pwrGood), .strobe(strobe),
    .qualLow(qualLow), .kickS(kickS), .status(status)
  );

  sup_ctrl u_ctrl (
    .clk(clk), .rstN(pwrGood), .pwrGoodS(pwrGoodS), .status(status),
    .strobe(strobe), .rstOut(rstOut), .wdExpN(wdExpN)
  );

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int CLKS_PER_MS = 50000,
  parameter int RESET_MS = 200
) (
  input logic clk,
  input logic pwrGood,
  input logic pfCmpHigh,
  input logic rstOut,
  input logic wdExpN,
  input logic pwrFailN
);

  logic [31:0] hiCnt;
  logic [1:0]  upCnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)    hiCnt <= '0;
    else if (rstOut) hiCnt <= hiCnt + 1'b1;
    else             hiCnt <= '0;
  end

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)           upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 1'b1;
  end

  // R2: reset is held while the supply is not good
  always @(posedge clk) begin
    if (!pwrGood) begin
      a_r2_reset_when_unpowered: assert (rstOut)
        else $error("rstOut low while pwrGood low");
    end
  end

  // R1: no reset pulse shorter than the programmed length
  a_r1_pulse_min_length: assert property (@(posedge clk) disable iff (!pwrGood)
    $fell(rstOut) |-> (hiCnt >= 32'((RESET_MS - 1) * CLKS_PER_MS)));

  // R7: expiry flag is high once reset has been held for a cycle
  a_r7_flag_high_in_reset: assert property (@(posedge clk) disable iff (!pwrGood)
    (rstOut && $past(rstOut)) |-> wdExpN);

  // R11: expiry flag only recovers through a reset
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(wdExpN) |-> $past(rstOut));

  // R9: power-fail flag follows the compare input two clocks later
  a_r9_pf_follows: assert property (@(posedge clk) disable iff (!pwrGood)
    (upCnt == 2'd3) |-> (pwrFailN == $past(pfCmpHigh, 2)));

endmodule

bind mcu_supervisor sup_checker #(
  .CLKS_PER_MS(CLKS_PER_MS), .RESET_MS(RESET_MS)
) u_supChk (
  .clk(clk), .pwrGood(pwrGood), .pfCmpHigh(pfCmpHigh),
  .rstOut(rstOut), .wdExpN(wdExpN), .pwrFailN(pwrFailN)
);

// File: tb/mcu_supervisor_bench.sv
module mcu_supervisor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CPM = 4;
  localparam int RST_MS = 10;
  localparam int MAN_MS = 8;
  localparam int WD_MS = 20;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic pwrGood = 1'b1;
  logic manRstN = 1'b1;
  logic wdKick = 1'b0;
  logic pfCmpHigh = 1'b1;
  logic rstOut, wdExpN, pwrFailN;

  mcu_supervisor #(
    .CLKS_PER_MS(CPM), .RESET_MS(RST_MS), .MANUAL_MS(MAN_MS), .WDOG_MS(WD_MS)
  ) u_mcu_supervisor (
    .clk(clk), .pwrGood(pwrGood), .manRstN(manRstN), .wdKick(wdKick),
    .pfCmpHigh(pfCmpHigh), .rstOut(rstOut), .wdExpN(wdExpN), .pwrFailN(pwrFailN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int rstRises = 0;
  logic prevRst = 1'b1;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rstOut && !prevRst) rstRises++;
    prevRst = rstOut;
  end

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // expected windows, in cycles, computed from the requirements
  function automatic int powerLo(); return (RST_MS - 1) * CPM; endfunction
  function automatic int powerHi(); return RST_MS * CPM + CPM + 6; endfunction
  function automatic int pulseLo(); return (RST_MS - 1) * CPM; endfunction
  function automatic int pulseHi(); return RST_MS * CPM + 3; endfunction
  function automatic int pressLo(); return MAN_MS * CPM + 1; endfunction
  function automatic int pressHi(); return (MAN_MS + 1) * CPM + 5; endfunction
  function automatic int expQualLo(); return MAN_MS * CPM; endfunction
  function automatic int expQualHi(); return (MAN_MS + 1) * CPM + 3; endfunction
  function automatic int wdLo(); return (WD_MS - 1) * CPM; endfunction
  function automatic int wdHi(); return WD_MS * CPM + 4; endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyclesN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    wdKick = 1'b1;
    cyclesN(3);
    wdKick = 1'b0;
    cyclesN(1);
  endtask

  task automatic waitRst(input logic v, output int t);
    while (rstOut !== v) @(negedge clk);
    t = cyc;
  endtask

  task automatic waitExp(input logic v, output int t);
    while (wdExpN !== v) @(negedge clk);
    t = cyc;
  endtask

  initial begin
    int t0, tFall, tRise, tExp, tPress, rises0;
    void'($urandom(32'd2718));

    #1 pwrGood = 1'b0;
    cyclesN(5);
    checkEq("R2 reset held while unpowered", int'(rstOut), 1);
    checkEq("R9 power-fail low while unpowered", int'(pwrFailN), 0);
    checkEq("R7 expiry flag idle high", int'(wdExpN), 1);

    // R1 power-on pulse
    pwrGood = 1'b1;
    t0 = cyc;
    waitRst(1'b0, tFall);
    checkRange("R1 power-on pulse length", tFall - t0, powerLo(), powerHi());

    // R9 random compare levels
    kick();
    for (int i = 0; i < 20; i++) begin
      pfCmpHigh = 1'($urandom_range(0, 1));
      cyclesN(3);
      checkEq("R9 power-fail follows compare", int'(pwrFailN), int'(pfCmpHigh));
    end
    pfCmpHigh = 1'b1;

    // R5 random kick spacing
    for (int i = 0; i < 8; i++) begin
      kick();
      cyclesN($urandom_range(1, (WD_MS - 2) * CPM - 4));
      checkEq("R5 fed watchdog flag", int'(wdExpN), 1);
      checkEq("R5 fed watchdog no reset", int'(rstOut), 0);
    end

    // R3 short manual pulses are ignored
    rises0 = rstRises;
    for (int i = 0; i < 6; i++) begin
      kick();
      manRstN = 1'b0;
      cyclesN((i == 0) ? MAN_MS * CPM - 1 : $urandom_range(1, MAN_MS * CPM - 1));
      manRstN = 1'b1;
      cyclesN(4);
      checkEq("R3 short press gives no reset", rstRises - rises0, 0);
      checkEq("R3 short press leaves flag", int'(wdExpN), 1);
    end

    // R4 qualified manual press
    kick();
    manRstN = 1'b0;
    tPress = cyc;
    waitRst(1'b1, tRise);
    checkRange("R4 reset start after press", tRise - tPress, pressLo(), pressHi());
    cyclesN(MAN_MS * CPM);
    manRstN = 1'b1;
    waitRst(1'b0, tFall);
    checkRange("R4 manual reset pulse length", tFall - tRise, pulseLo(), pulseHi());

    // R8 watchdog timed from reset release, R11 sticky flag, R7 looped reset
    waitExp(1'b0, tExp);
    checkRange("R8 expiry timed from reset release", tExp - tFall, wdLo(), wdHi());
    cyclesN(2);
    kick();
    checkEq("R11 flag stays low after late kick", int'(wdExpN), 0);
    checkEq("R11 no reset yet", int'(rstOut), 0);
    waitRst(1'b1, tRise);
    checkRange("R7 expiry qualified into reset", tRise - tExp, expQualLo(), expQualHi());
    cyclesN(1);
    checkEq("R7 flag high during reset", int'(wdExpN), 1);

    // R6 static-high kick does not feed the watchdog
    wdKick = 1'b1;
    waitRst(1'b0, tFall);
    waitExp(1'b0, tExp);
    checkRange("R6 static kick still expires", tExp - tFall, wdLo(), wdHi());
    waitRst(1'b1, tRise);
    wdKick = 1'b0;
    waitRst(1'b0, tFall);

    // R10 press begun before expiry keeps its qualification time
    while (cyc < tFall + (WD_MS - 6) * CPM) @(negedge clk);
    manRstN = 1'b0;
    tPress = cyc;
    waitRst(1'b1, tRise);
    checkRange("R10 shared qualification timing", tRise - tPress, pressLo(), pressHi());
    manRstN = 1'b1;
    waitRst(1'b0, tFall);

    // R2 supply dip restarts a full pulse
    kick();
    cyclesN(5);
    pwrGood = 1'b0;
    cyclesN(1);
    checkEq("R2 dip asserts reset", int'(rstOut), 1);
    checkEq("R9 dip forces power-fail low", int'(pwrFailN), 0);
    cyclesN(3);
    pwrGood = 1'b1;
    t0 = cyc;
    waitRst(1'b0, tFall);
    checkRange("R2 pulse after dip", tFall - t0, powerLo(), powerHi());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule